// File: doc/BRIEF.md
# Vertical-Clock Identification Streamer

This block is the power-up side of a dual-mode display identification memory. From reset it reads a 128-byte store one byte at a time and puts the bits onto a shared open-drain data line. Each bit advances on a rising edge of an external slow clock, which the display usually derives from its vertical sync. No address is sent, so a receiver that only counts sync pulses can collect the whole table.

The block also holds a one-way mode latch. While the two-wire bus clock stays high (idle), the block streams. The first falling edge on the bus clock moves it into bidirectional mode. It then lets go of the data line for the two-wire slave and freezes its position. Only a reset brings it back to streaming.

Both slow inputs are synchronised into the system clock domain and edge-detected there. The memory is reached through a combinational read port: the block presents an address, and the byte comes back in the same cycle.

Top module: `vis_id_streamer`

## Requirements
- R1: After reset the read address is 00h, the mode output is 0 (streaming), and the data line carries bit 7 of byte 00h.
- R2: Within a byte, bit slot k (k = 0..7) puts data bit 7-k on the line, so the most significant bit goes first.
- R3: Slot 8 of every byte is a released slot: the pull-low enable is 0 whatever the data.
- R4: Each rising edge of the vertical clock advances by one slot. After slot 8 the address goes up by one, and 7Fh is followed by 00h.
- R5: The output is open-drain: the pull-low enable is 1 exactly when the current data bit is 0 in streaming mode. Otherwise it is 0 and the line is released.
- R6: A high-to-low transition on the bus clock sets the mode output to 1 within four system clocks. From then on the pull-low enable stays 0.
- R7: In bidirectional mode, further vertical-clock pulses and bus-clock edges leave the mode at 1 and the read address unchanged.
- R8: Only reset clears bidirectional mode. After reset, streaming restarts from address 00h, slot 0.
- R9: A falling edge of the vertical clock does not advance the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vclk_in | input | 1 | Vertical-sync-derived bit clock |
| scl_in | input | 1 | Two-wire bus clock, watched for activity only |
| rd_addr | output | 7 | Read address into the byte store |
| rd_data | input | 8 | Byte returned for rd_addr in the same cycle |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| bidir_mode | output | 1 | 1 once the line belongs to the two-wire slave |

## Verification
The checker watches four things on every cycle:
- the latch never leaves bidirectional mode;
- the line stays released while that mode holds;
- the address only ever steps by one, modulo 128, and only out of the released ninth slot;
- the address does not move once the latch is set.

Only the bench's scenarios can show what the line actually carries: bit order and values against a computed table, across a full address wrap, including the all-zero and all-one bytes. The same holds for the timing of the switch after a bus-clock fall, and for the return to address 00h after reset.

// File: rtl/vis_id_pkg.sv
package vis_id_pkg;
  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_BIDIR  = 1'b1
  } vis_mode_e;
endpackage

// File: rtl/vis_sync_edge.sv
module vis_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = din;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], din};
    end
  endgenerate

  assign lvl = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sh_q   <= sh_d;
      prev_q <= lvl;
    end
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/vis_mode_latch.sv
module vis_mode_latch
  import vis_id_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_fall,
  output vis_mode_e mode
);
  vis_mode_e mode_q;
  vis_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (bus_fall) mode_d = MODE_BIDIR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_STREAM;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/vis_slot_seq.sv
module vis_slot_seq #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step,
  input  logic [DATA_W-1:0]         byte_in,
  output logic [ADDR_W-1:0]         addr,
  output logic [$clog2(DATA_W+1)-1:0] slot,
  output logic                      drive_low
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  slot_q, slot_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  bit_idx;
  logic              in_data;

  always_comb begin
    slot_d = slot_q;
    addr_d = addr_q;
    if (step) begin
      if (slot_q == LAST_SLOT) begin
        slot_d = '0;
        addr_d = addr_q + 1'b1;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      addr_q <= '0;
    end else if (step) begin
      slot_q <= slot_d;
      addr_q <= addr_d;
    end
  end

  assign in_data   = (slot_q != LAST_SLOT);
  assign bit_idx   = IDX_W'(DATA_W - 1) - slot_q[IDX_W-1:0];
  assign drive_low = in_data & ~byte_in[bit_idx];
  assign addr      = addr_q;
  assign slot      = slot_q;
endmodule

// File: rtl/vis_id_streamer.sv
module vis_id_streamer
  import vis_id_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_in,
  input  logic              scl_in,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              bidir_mode
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic             v_rise, v_fall_unused;
  logic             s_rise_unused, s_fall;
  vis_mode_e        mode;
  logic             streaming;
  logic             drive_low;
  logic [CNT_W-1:0] slot;

  vis_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vsync (
    .clk(clk), .rst_n(rst_n), .din(vclk_in),
    .rise(v_rise), .fall(v_fall_unused)
  );

  vis_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus (
    .clk(clk), .rst_n(rst_n), .din(scl_in),
    .rise(s_rise_unused), .fall(s_fall)
  );

  vis_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .bus_fall(s_fall), .mode(mode)
  );

  assign streaming = (mode == MODE_STREAM);

  vis_slot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .step(v_rise & streaming),
    .byte_in(rd_data),
    .addr(rd_addr),
    .slot(slot),
    .drive_low(drive_low)
  );

  assign sda_pull   = streaming & drive_low;
  assign bidir_mode = ~streaming;
endmodule

// File: rtl/vis_id_streamer_chk.sv
module vis_id_streamer_chk #(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              sda_pull,
  input logic              bidir_mode,
  input logic [CNT_W-1:0]  slot
);
  a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |=> bidir_mode);

  a_r6_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |-> !sda_pull);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

  a_r3_step_from_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> ($past(slot) == CNT_W'(DATA_W)));

  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |=> $stable(rd_addr));
endmodule

bind vis_id_streamer vis_id_streamer_chk #(
  .ADDR_W(ADDR_W), .CNT_W($clog2(DATA_W + 1)), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr),
  .sda_pull(sda_pull), .bidir_mode(bidir_mode), .slot(slot)
);

// File: tb/test_vis_id_streamer.sv
module test_vis_id_streamer;
  logic       clk;
  logic       rst_n;
  logic       vclk_in;
  logic       scl_in;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       sda_pull;
  logic       bidir_mode;

  int checks;
  int errors;
  bit done;

  vis_id_streamer i_vis_id_streamer (
    .clk(clk), .rst_n(rst_n), .vclk_in(vclk_in), .scl_in(scl_in),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sda_pull(sda_pull), .bidir_mode(bidir_mode)
  );

  function automatic logic [7:0] pat(input int a);
    if (a == 3) return 8'h00;
    if (a == 4) return 8'hFF;
    return 8'((a * 37 + 90) ^ (a >> 2));
  endfunction

  assign rd_data = pat(int'(rd_addr));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic vpulse();
    vclk_in = 1'b1;
    idle(5);
    vclk_in = 1'b0;
    idle(5);
  endtask

  // expected pull for byte a, slot s
  function automatic int exp_pull(input int a, input int s);
    logic [7:0] b;
    b = pat(a);
    if (s == 8) return 0;
    return (b[7 - s] == 1'b0) ? 1 : 0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    vclk_in = 1'b0;
    scl_in = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    int frozen;
    checks = 0;
    errors = 0;
    do_reset();
    // R1 reset state
    chk("R1 addr", int'(rd_addr), 0);
    chk("R1 mode", int'(bidir_mode), 0);
    chk("R1 first bit", int'(sda_pull), exp_pull(0, 0));

    // R2 R3 R4 R5 R9: full sweep past the wrap
    for (int s = 0; s < 128 * 9 + 20; s++) begin
      int a;
      int k;
      a = (s / 9) % 128;
      k = s % 9;
      chk("R4 addr", int'(rd_addr), a);
      if (k == 8) chk("R3 gap", int'(sda_pull), 0);
      else        chk("R2 R5 bit", int'(sda_pull), exp_pull(a, k));
      vclk_in = 1'b1;
      idle(5);
      // after rise, slot has advanced; falling edge below must not advance (R9)
      vclk_in = 1'b0;
      idle(5);
    end

    // R6 bus clock falls
    frozen = int'(rd_addr);
    scl_in = 1'b0;
    idle(5);
    chk("R6 mode", int'(bidir_mode), 1);
    chk("R6 released", int'(sda_pull), 0);

    // R7 activity in bidir mode
    for (int i = 0; i < 20; i++) begin
      scl_in = ~scl_in;
      vpulse();
      chk("R7 addr", int'(rd_addr), frozen);
      chk("R7 mode", int'(bidir_mode), 1);
      chk("R7 line", int'(sda_pull), 0);
    end

    // R8 reset restores streaming
    do_reset();
    chk("R8 mode", int'(bidir_mode), 0);
    for (int s = 0; s < 27; s++) begin
      chk("R8 addr", int'(rd_addr), s / 9);
      chk("R8 bit", int'(sda_pull), exp_pull(s / 9, s % 9));
      vpulse();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule